// File: doc/BRIEF.md
# Fracturable Sub-Word SIMD Multiplier

This block is the multiply unit of one 32-bit vector lane. On each accepted beat it takes two packed 32-bit operands and a mode. It then computes one of three things:

- a single full 32x32 product;
- two independent 16x16 products, one per halfword lane;
- four independent 8x8 products, one per byte lane.

The same six multipliers serve every mode.

- **Word mode** joins four 18x18 partial products into a 64-bit result. It shifts the two cross terms left by 16 bits and the high term left by 32 bits.
- **Narrow modes** drive the same wide multipliers with sign- or zero-extended sub-word operands. Two extra 9x9 multipliers handle bytes 2 and 3.
- **Sharing:** the lowest multiplier serves byte 0, halfword 0 and the low word term. The second multiplier serves byte 1, halfword 1 and one of the word cross terms.

Operands enter through a valid/ready stream and results leave through another.

- A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- A result is consumed on an edge where `out_valid` and `out_ready` are both high.
- The two pipeline stages stall together. While a result waits unconsumed, `in_ready` is low and the held result does not change.
- With the output free, a result appears two cycles after its beat is accepted in every mode, at a rate of one result per cycle.

Top module: `simd_mul`

## Requirements
- R1: With `mode` = 2'b00 and `is_signed` low, `prod` is the full 64-bit unsigned product `a*b`.
- R2: With `mode` = 2'b00 and `is_signed` high, `prod` is the 64-bit two's-complement product of `a` and `b`.
- R3: With `mode` = 2'b01, each halfword lane i (bits 16i+15:16i, i=0,1) multiplies `a` lane i by `b` lane i to a 32-bit product. The lane returns bits 31:16 of that product when `hi_sel` is high, else bits 15:0. `prod[63:32]` is zero.
- R4: With `mode` = 2'b10 or 2'b11, each byte lane i (bits 8i+7:8i, i=0..3) multiplies the byte lanes to a 16-bit product. The lane returns bits 15:8 of that product when `hi_sel` is high, else bits 7:0. `prod[63:32]` is zero.
- R5: In halfword and byte modes every sub-word operand is sign-extended when `is_signed` is high and zero-extended when it is low. No lane's result depends on any other lane's operands.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `prod` holds its value.
- R7: With `out_ready` high, the result of a beat accepted at edge k is presented after edge k+2 in every mode. Back-to-back beats yield results in order, one per cycle.
- R8: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, and low otherwise.
- R9: In word mode `hi_sel` has no effect on `prod`.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| a | input | 32 | Packed multiplicand |
| b | input | 32 | Packed multiplier |
| mode | input | 2 | 00 word, 01 halfword, 1x byte |
| is_signed | input | 1 | Two's-complement operands when high |
| hi_sel | input | 1 | Return upper half of each narrow product |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| prod | output | 64 | Product or packed lane results |

## Verification
The word mode is driven with all-ones, most-negative and mixed-sign operand pairs. These tell correct shifting and sign handling of the cross and high partial products apart from a mere low-half product. The narrow modes use lanes with differing signs and the extreme values 0x80, 0xFF, 0x8000 and 0xFFFF, under both `hi_sel` settings. A lane wrongly wired to its neighbour, or extended the wrong way, shows up as a wrong upper half. A stalled stream with a queued beat, and a back-to-back burst that mixes modes, separate correct hold and ordering from a pipeline that drops or duplicates results.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  typedef enum logic [1:0] {
    MODE_WORD  = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_BYTE  = 2'b10,
    MODE_BYTE2 = 2'b11
  } mul_mode_e;
endpackage

// File: rtl/simd_mul_steer.sv
module simd_mul_steer
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = DATA_W / 4,
  localparam int PP_W = HALF_W + 2,
  localparam int SM_W = BYTE_W + 1
) (
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  input  mul_mode_e                  mode,
  input  logic                       is_signed,
  output logic [3:0][PP_W-1:0]       wide_a,
  output logic [3:0][PP_W-1:0]       wide_b,
  output logic [1:0][SM_W-1:0]       small_a,
  output logic [1:0][SM_W-1:0]       small_b
);
  function automatic logic [PP_W-1:0] ext_half(input logic [HALF_W-1:0] x, input logic s);
    return {{(PP_W-HALF_W){s & x[HALF_W-1]}}, x};
  endfunction

  function automatic logic [PP_W-1:0] ext_byte(input logic [BYTE_W-1:0] x, input logic s);
    return {{(PP_W-BYTE_W){s & x[BYTE_W-1]}}, x};
  endfunction

  function automatic logic [SM_W-1:0] ext_small(input logic [BYTE_W-1:0] x, input logic s);
    return {s & x[BYTE_W-1], x};
  endfunction

  logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
  assign a_lo = a[HALF_W-1:0];
  assign a_hi = a[DATA_W-1:HALF_W];
  assign b_lo = b[HALF_W-1:0];
  assign b_hi = b[DATA_W-1:HALF_W];

  always_comb begin
    wide_a  = '0;
    wide_b  = '0;
    small_a = '0;
    small_b = '0;
    unique case (mode)
      MODE_WORD: begin
        // low halves are magnitudes; only the upper halves carry the sign
        wide_a[0] = ext_half(a_lo, 1'b0);      wide_b[0] = ext_half(b_lo, 1'b0);
        wide_a[1] = ext_half(a_lo, 1'b0);      wide_b[1] = ext_half(b_hi, is_signed);
        wide_a[2] = ext_half(a_hi, is_signed); wide_b[2] = ext_half(b_lo, 1'b0);
        wide_a[3] = ext_half(a_hi, is_signed); wide_b[3] = ext_half(b_hi, is_signed);
      end
      MODE_HALF: begin
        wide_a[0] = ext_half(a_lo, is_signed); wide_b[0] = ext_half(b_lo, is_signed);
        wide_a[1] = ext_half(a_hi, is_signed); wide_b[1] = ext_half(b_hi, is_signed);
      end
      default: begin
        wide_a[0]  = ext_byte(a[0*BYTE_W +: BYTE_W], is_signed);
        wide_b[0]  = ext_byte(b[0*BYTE_W +: BYTE_W], is_signed);
        wide_a[1]  = ext_byte(a[1*BYTE_W +: BYTE_W], is_signed);
        wide_b[1]  = ext_byte(b[1*BYTE_W +: BYTE_W], is_signed);
        small_a[0] = ext_small(a[2*BYTE_W +: BYTE_W], is_signed);
        small_b[0] = ext_small(b[2*BYTE_W +: BYTE_W], is_signed);
        small_a[1] = ext_small(a[3*BYTE_W +: BYTE_W], is_signed);
        small_b[1] = ext_small(b[3*BYTE_W +: BYTE_W], is_signed);
      end
    endcase
  end
endmodule

// File: rtl/simd_mul_mult.sv
module simd_mul_mult #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 36
) (
  input  logic [IN_W-1:0]  op_a,
  input  logic [IN_W-1:0]  op_b,
  output logic [OUT_W-1:0] product
);
  logic signed [OUT_W-1:0] xa, xb;
  assign xa = OUT_W'($signed(op_a));
  assign xb = OUT_W'($signed(op_b));
  assign product = xa * xb;
endmodule

// File: rtl/simd_mul_merge.sv
module simd_mul_merge
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = DATA_W / 4,
  localparam int PP_W = HALF_W + 2,
  localparam int WP_W = 2 * PP_W,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [3:0][WP_W-1:0]       wide_p,
  input  logic [1:0][2*BYTE_W-1:0]   small_p,
  input  mul_mode_e                  mode,
  input  logic                       hi_sel,
  output logic [RES_W-1:0]           result
);
  logic signed [RES_W-1:0] e0, e1, e2, e3, word_sum;
  assign e0 = RES_W'($signed(wide_p[0]));
  assign e1 = RES_W'($signed(wide_p[1]));
  assign e2 = RES_W'($signed(wide_p[2]));
  assign e3 = RES_W'($signed(wide_p[3]));
  assign word_sum = e0 + ((e1 + e2) <<< HALF_W) + (e3 <<< DATA_W);

  logic [3:0][2*BYTE_W-1:0] byte_p;
  assign byte_p = {small_p[1], small_p[0], wide_p[1][2*BYTE_W-1:0], wide_p[0][2*BYTE_W-1:0]};

  logic [DATA_W-1:0] half_res, byte_res;
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_res[h*HALF_W +: HALF_W] =
      hi_sel ? wide_p[h][DATA_W-1:HALF_W] : wide_p[h][HALF_W-1:0];
  end
  for (genvar y = 0; y < 4; y++) begin : g_byte
    assign byte_res[y*BYTE_W +: BYTE_W] =
      hi_sel ? byte_p[y][2*BYTE_W-1:BYTE_W] : byte_p[y][BYTE_W-1:0];
  end

  always_comb begin
    unique case (mode)
      MODE_WORD: result = word_sum;
      MODE_HALF: result = {{DATA_W{1'b0}}, half_res};
      default:   result = {{DATA_W{1'b0}}, byte_res};
    endcase
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int BYTE_W = DATA_W / 4,
  localparam int PP_W = HALF_W + 2,
  localparam int SM_W = BYTE_W + 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        mode,
  input  logic              is_signed,
  input  logic              hi_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  prod
);
  mul_mode_e in_mode;
  assign in_mode = mul_mode_e'(mode);

  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  logic [3:0][PP_W-1:0] wide_a, wide_b;
  logic [1:0][SM_W-1:0] small_a, small_b;

  simd_mul_steer #(.DATA_W(DATA_W)) u_steer (
    .a(a), .b(b), .mode(in_mode), .is_signed(is_signed),
    .wide_a(wide_a), .wide_b(wide_b), .small_a(small_a), .small_b(small_b)
  );

  logic [3:0][2*PP_W-1:0]   wide_p, s1_wide_p;
  logic [1:0][2*BYTE_W-1:0] small_p, s1_small_p;

  for (genvar i = 0; i < 4; i++) begin : g_wide
    simd_mul_mult #(.IN_W(PP_W), .OUT_W(2*PP_W)) u_mult (
      .op_a(wide_a[i]), .op_b(wide_b[i]), .product(wide_p[i])
    );
  end
  for (genvar j = 0; j < 2; j++) begin : g_small
    simd_mul_mult #(.IN_W(SM_W), .OUT_W(2*BYTE_W)) u_mult (
      .op_a(small_a[j]), .op_b(small_b[j]), .product(small_p[j])
    );
  end

  // stage 1: partial products
  logic      s1_valid, s1_hi;
  mul_mode_e s1_mode;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
    end
  end
  always_ff @(posedge clk) begin
    if (advance && in_valid) begin
      s1_wide_p  <= wide_p;
      s1_small_p <= small_p;
      s1_mode    <= in_mode;
      s1_hi      <= hi_sel;
    end
  end

  logic [RES_W-1:0] merged;
  simd_mul_merge #(.DATA_W(DATA_W)) u_merge (
    .wide_p(s1_wide_p), .small_p(s1_small_p), .mode(s1_mode),
    .hi_sel(s1_hi), .result(merged)
  );

  // stage 2: combined result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_valid;
    end
  end
  always_ff @(posedge clk) begin
    if (advance && s1_valid) begin
      prod <= merged;
    end
  end
endmodule

// File: rtl/simd_mul_checker.sv
module simd_mul_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*DATA_W-1:0] prod
);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(prod)));

  a_r7_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);

  a_r8_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

bind simd_mul simd_mul_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .prod(prod)
);

// File: tb/simd_mul_test.sv
`timescale 1ns/1ps
module simd_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  mode = 2'b00;
  logic        is_signed = 1'b0, hi_sel = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] prod;

  always #2 clk = ~clk;

  simd_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .mode(mode), .is_signed(is_signed), .hi_sel(hi_sel),
    .out_valid(out_valid), .out_ready(out_ready), .prod(prod)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit lat_on = 1'b0;
  string cur_tag = "R1";
  logic [63:0] exp_q [0:63];
  string       tag_q [0:63];
  int          acc_q [0:63];
  int wr = 0, rd = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [1:0] m, input logic s, input logic h);
    logic [63:0] r;
    r = '0;
    if (m == 2'b00) begin
      if (s) r = {{32{x[31]}}, x} * {{32{y[31]}}, y};
      else   r = {32'b0, x} * {32'b0, y};
    end else if (m == 2'b01) begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] p;
        p = {{16{s & x[16*i+15]}}, x[16*i +: 16]} * {{16{s & y[16*i+15]}}, y[16*i +: 16]};
        r[16*i +: 16] = h ? p[31:16] : p[15:0];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] p;
        p = {{8{s & x[8*i+7]}}, x[8*i +: 8]} * {{8{s & y[8*i+7]}}, y[8*i +: 8]};
        r[8*i +: 8] = h ? p[15:8] : p[7:0];
      end
    end
    return r;
  endfunction

  // scoreboard: pops a result and records each accepted beat
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (rd == wr) begin
          check("R7 unexpected result", prod, 64'hx);
        end else begin
          check(tag_q[rd], prod, exp_q[rd]);
          if (lat_on) check("R7 latency", 64'(cyc - acc_q[rd]), 64'd2);
          rd++;
        end
      end
      if (in_valid && in_ready) begin
        exp_q[wr] = model(a, b, mode, is_signed, hi_sel);
        tag_q[wr] = cur_tag;
        acc_q[wr] = cyc;
        wr++;
      end
    end
  end

  task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m,
                      input logic s, input logic h, input string tag);
    a = x; b = y; mode = m; is_signed = s; hi_sel = h; cur_tag = tag;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    #1;
    check("R7 all results returned", 64'(rd), 64'(wr));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 out_valid in reset", 64'(out_valid), 64'd0);
    check("R10 in_ready in reset", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_word_unsigned();
    lat_on = 1'b1;
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0, "R1 all ones");
    send(32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 1'b0, 1'b0, "R1 mixed");
    send(32'h8000_0000, 32'h0000_0002, 2'b00, 1'b0, 1'b0, "R1 top bit");
    drain();
  endtask

  task automatic t_word_signed();
    send(32'h8000_0000, 32'h8000_0000, 2'b00, 1'b1, 1'b0, "R2 min*min");
    send(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b1, 1'b0, "R2 -1*1");
    send(32'h7FFF_FFFF, 32'h8000_0000, 2'b00, 1'b1, 1'b0, "R2 max*min");
    send(32'hFFFE_0003, 32'h0001_FFFD, 2'b00, 1'b1, 1'b0, "R2 cross terms");
    drain();
  endtask

  task automatic t_hi_word();
    send(32'hDEAD_BEEF, 32'hCAFE_F00D, 2'b00, 1'b1, 1'b1, "R9 hi_sel in word mode");
    send(32'hDEAD_BEEF, 32'hCAFE_F00D, 2'b00, 1'b0, 1'b1, "R9 hi_sel unsigned word");
    drain();
  endtask

  task automatic t_half();
    send(32'h8000_FFFF, 32'h8000_FFFF, 2'b01, 1'b0, 1'b1, "R3 unsigned high");
    send(32'h8000_FFFF, 32'h8000_FFFF, 2'b01, 1'b1, 1'b1, "R5 signed halfword high");
    send(32'h1234_FFFE, 32'h00F0_0003, 2'b01, 1'b1, 1'b0, "R3 signed low");
    send(32'hFFFF_0001, 32'h0001_7FFF, 2'b01, 1'b0, 1'b0, "R5 halfword lanes isolated");
    drain();
  endtask

  task automatic t_byte();
    send(32'h80FF_7F80, 32'h80FF_0280, 2'b10, 1'b1, 1'b1, "R4 signed high");
    send(32'h80FF_7F80, 32'h80FF_0280, 2'b10, 1'b0, 1'b1, "R5 unsigned byte high");
    send(32'h0312_FF05, 32'h7F03_FF07, 2'b11, 1'b1, 1'b0, "R4 alt code low");
    send(32'hFF01_FF01, 32'h01FF_01FF, 2'b10, 1'b0, 1'b1, "R5 byte lanes isolated");
    drain();
  endtask

  task automatic t_stall();
    logic [63:0] held;
    lat_on = 1'b0;
    out_ready = 1'b0;
    send(32'h0000_0007, 32'h0000_0009, 2'b00, 1'b0, 1'b0, "R6 first held");
    send(32'h0102_0304, 32'h0506_0708, 2'b10, 1'b0, 1'b0, "R6 second queued");
    a = 32'h0000_FFFF; b = 32'h0000_FFFF; mode = 2'b01; is_signed = 1'b1;
    hi_sel = 1'b0; cur_tag = "R8 third waits"; in_valid = 1'b1;
    @(negedge clk);
    held = prod;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 out_valid held", 64'(out_valid), 64'd1);
      check("R6 prod held", prod, held);
      check("R8 in_ready low when stalled", 64'(in_ready), 64'd0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 in_ready on out_ready", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();
  endtask

  task automatic t_burst();
    lat_on = 1'b1;
    for (int n = 0; n < 12; n++) begin
      send(32'h9E37_79B9 * (n + 1), 32'h7F4A_7C15 ^ (n * 32'h0101_0101),
           2'(n % 3), n[0], n[1], "R7 burst");
    end
    drain();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(posedge clk); #1;
    t_word_unsigned();
    t_word_signed();
    t_hi_word();
    t_half();
    t_byte();
    t_stall();
    t_burst();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule